// File: doc/BRIEF.md
# Half-Bridge PWM with Fault Trip and Restart

This block drives one PWM channel as two complementary outputs, a primary and a secondary, for a half-bridge power stage. A free-running counter sets the period, and a compare value sets the duty. A programmable guard interval keeps one output from turning on until the other has been off for that many cycles. Period, duty and guard values are captured at each period boundary, so software may rewrite them at any time without producing a torn cycle.

A fault latch watches two kinds of trip source. The first is a set of comparator inputs that act as levels. The second is a set of external inputs that act on a rising edge. While the latch is set, both drive outputs are held at their off level after the polarity select is applied. Software may also set the latch or clear it through a one-bit write port. When the latch clears, either by itself or by a software write, output activity resumes only at the next period boundary. A ready flag reports that one full period with captured settings has completed since reset.

Top module: `hb_pwm_top`

## Requirements
- R1: The counter runs from 0 to the captured period value P and then wraps. `period_match_o` pulses high for one cycle as each new period begins, so pulses are P+1 cycles apart.
- R2: With a guard of 0, the primary output is on for D cycles of each period and the secondary for P+1-D cycles, where D is the captured duty. D=0 keeps the primary off and the secondary on all the time. D>P keeps the primary on and the secondary off all the time.
- R3: With a guard value G, each output turns on G cycles after the other turns off. The primary is on for D-G cycles and the secondary for P+1-D-G cycles, and both are never on together.
- R4: A polarity bit of 0 makes its output active-high. A value of 1 makes it active-low, so the off level on the pin equals the polarity bit.
- R5: New period, duty and guard values written during a period take effect only from the next period boundary.
- R6: With `restart_en_i`=1, the trip status clears in the cycle after every comparator input is low, every external input is low, and no software write is pending.
- R7: With `restart_en_i`=0, the trip status stays set after the fault goes away until software writes 0 (`sw_wr_i`=1, `sw_wdata_i`=0).
- R8: After the trip status clears, both outputs stay off until the next `period_match_o` pulse. Normal activity follows from there.
- R9: A high comparator input sets the trip status and keeps it set. A software write of 0 has no effect while any trip source is active.
- R10: A software write of 1 with no trip source active sets the trip status.
- R11: A rising edge on any external trip input sets the trip status.
- R12: In the cycle after the trip status is set, both outputs are at their off level.
- R13: `ready_o` is 0 out of reset. It rises in the cycle after the second `period_match_o` pulse and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Period value P (period lasts P+1 cycles) |
| duty_i | input | CNT_W | Duty compare value D |
| dtime_i | input | DT_W | Guard interval G in cycles |
| pol_a_i | input | 1 | Primary polarity: 0 active-high, 1 active-low |
| pol_b_i | input | 1 | Secondary polarity: 0 active-high, 1 active-low |
| restart_en_i | input | 1 | 1 selects automatic restart, 0 selects latched trip |
| cmp_trip_i | input | N_CMP | Comparator trip sources, level sensitive |
| ext_trip_i | input | N_EXT | External trip sources, rising-edge sensitive |
| sw_wr_i | input | 1 | Software write strobe for the trip status |
| sw_wdata_i | input | 1 | Value to write to the trip status |
| drv_a_o | output | 1 | Primary drive output |
| drv_b_o | output | 1 | Secondary drive output |
| trip_o | output | 1 | Trip status |
| period_match_o | output | 1 | One-cycle pulse at each period start |
| ready_o | output | 1 | One full period has completed since reset |

## Verification
The assertions assume that the trip inputs and the write strobe are synchronous to the clock. They also assume that `restart_en_i` stays steady across the cycle in which a clear or hold is judged. The stimulus changes every input only at falling edges and changes restart mode only while the latch is idle. Duty and period counts are compared only after two boundaries with unchanged settings, so the B-output tail that crosses each boundary is in steady state. Guard values are kept below the duty and off-time they shorten.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;

   typedef enum logic {
      POL_ACT_HIGH = 1'b0,
      POL_ACT_LOW  = 1'b1
   } pol_e;

   localparam int SIDE_A = 0;
   localparam int SIDE_B = 1;
   localparam int N_SIDE = 2;

   // Pin level for an internal active flag under a polarity select.
   function automatic logic drive_level(input logic act, input logic pol);
      return act ^ pol;
   endfunction

endpackage

// File: rtl/hb_pwm_timebase.sv
module hb_pwm_timebase #(
   parameter int CNT_W = 8,
   parameter int DT_W  = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [DT_W-1:0]  dtime_i,
   output logic             pri_o,
   output logic [DT_W-1:0]  dt_o,
   output logic             wrap_o,
   output logic             pm_o,
   output logic             ready_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] duty_q;
   logic [DT_W-1:0]  dt_q;
   logic             pm_q;
   logic             seen_q;
   logic             ready_q;

   assign wrap_o = (cnt_q == per_q);

   // Counter plus shadow capture at the boundary
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         per_q  <= '0;
         duty_q <= '0;
         dt_q   <= '0;
      end else if (wrap_o) begin
         cnt_q  <= '0;
         per_q  <= period_i;
         duty_q <= duty_i;
         dt_q   <= dtime_i;
      end else begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   // Boundary flag and start-up guard
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pm_q    <= 1'b0;
         seen_q  <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         pm_q    <= wrap_o;
         seen_q  <= seen_q | pm_q;
         ready_q <= ready_q | (pm_q & seen_q);
      end
   end

   assign pri_o   = (cnt_q < duty_q);
   assign dt_o    = dt_q;
   assign pm_o    = pm_q;
   assign ready_o = ready_q;

endmodule

// File: rtl/hb_pwm_trip.sv
module hb_pwm_trip #(
   parameter int N_CMP    = 2,
   parameter int N_EXT    = 1,
   parameter bit EXT_RISE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_en_i,
   input  logic [N_CMP-1:0] cmp_i,
   input  logic [N_EXT-1:0] ext_i,
   input  logic             sw_wr_i,
   input  logic             sw_wdata_i,
   input  logic             wrap_i,
   output logic             trip_o,
   output logic             run_o
);

   logic [N_EXT-1:0] ext_lvl;
   logic [N_EXT-1:0] ext_prev_q;
   logic [N_EXT-1:0] ext_edge;
   logic             cmp_any;
   logic             cond;
   logic             trip_q;
   logic             trip_d;
   logic             run_q;

   // Active sense of the external sources is a build option
   generate
      if (EXT_RISE) begin : g_ext_rise
         assign ext_lvl = ext_i;
      end else begin : g_ext_fall
         assign ext_lvl = ~ext_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ext_prev_q <= '0;
      else         ext_prev_q <= ext_lvl;
   end

   assign ext_edge = ext_lvl & ~ext_prev_q;
   assign cmp_any  = |cmp_i;
   assign cond     = cmp_any | (|ext_lvl);

   always_comb begin
      trip_d = trip_q;
      if (cmp_any || (|ext_edge))  trip_d = 1'b1;
      else if (cond)               trip_d = trip_q;
      else if (sw_wr_i)            trip_d = sw_wdata_i;
      else if (restart_en_i)       trip_d = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trip_q <= 1'b0;
      else         trip_q <= trip_d;
   end

   // Output enable: dropped at once, restored only at a boundary
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 run_q <= 1'b0;
      else if (trip_q)             run_q <= 1'b0;
      else if (wrap_i && !run_q)   run_q <= 1'b1;
   end

   assign trip_o = trip_q;
   assign run_o  = run_q;

endmodule

// File: rtl/hb_pwm_deadband.sv
module hb_pwm_deadband
   import hb_pwm_pkg::*;
#(
   parameter int DT_W = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic            pri_i,
   input  logic [DT_W-1:0] dt_i,
   input  logic            pol_a_i,
   input  logic            pol_b_i,
   output logic            a_act_o,
   output logic            b_act_o,
   output logic            drv_a_o,
   output logic            drv_b_o
);

   localparam logic [DT_W-1:0] SAT = {DT_W{1'b1}};

   logic [N_SIDE-1:0] req;
   logic [N_SIDE-1:0] act_q;
   logic [N_SIDE-1:0] pol;

   assign req[SIDE_A] = en_i &  pri_i;
   assign req[SIDE_B] = en_i & ~pri_i;
   assign pol[SIDE_A] = pol_a_i;
   assign pol[SIDE_B] = pol_b_i;

   generate
      for (genvar s = 0; s < N_SIDE; s++) begin : g_side
         logic [DT_W-1:0] hold_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)           hold_q <= '0;
            else if (!req[s])      hold_q <= '0;
            else if (hold_q != SAT) hold_q <= hold_q + DT_W'(1);
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) act_q[s] <= 1'b0;
            else         act_q[s] <= req[s] && (hold_q >= dt_i);
         end
      end
   endgenerate

   assign a_act_o = act_q[SIDE_A];
   assign b_act_o = act_q[SIDE_B];
   assign drv_a_o = drive_level(act_q[SIDE_A], pol[SIDE_A]);
   assign drv_b_o = drive_level(act_q[SIDE_B], pol[SIDE_B]);

endmodule

// File: rtl/hb_pwm_top.sv
module hb_pwm_top #(
   parameter int CNT_W    = 8,
   parameter int DT_W     = 4,
   parameter int N_CMP    = 2,
   parameter int N_EXT    = 1,
   parameter bit EXT_RISE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [DT_W-1:0]  dtime_i,
   input  logic             pol_a_i,
   input  logic             pol_b_i,
   input  logic             restart_en_i,
   input  logic [N_CMP-1:0] cmp_trip_i,
   input  logic [N_EXT-1:0] ext_trip_i,
   input  logic             sw_wr_i,
   input  logic             sw_wdata_i,
   output logic             drv_a_o,
   output logic             drv_b_o,
   output logic             trip_o,
   output logic             period_match_o,
   output logic             ready_o
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("hb_pwm_top: CNT_W must be at least 2");
      end
      if (DT_W < 1 || DT_W > CNT_W) begin : g_bad_dt
         $error("hb_pwm_top: DT_W must be in 1..CNT_W");
      end
      if (N_CMP < 1 || N_EXT < 1) begin : g_bad_src
         $error("hb_pwm_top: at least one source of each kind");
      end
   endgenerate

   logic            pri;
   logic [DT_W-1:0] dt_cur;
   logic            wrap;
   logic            trip;
   logic            run;
   logic            out_en;
   logic            a_act;
   logic            b_act;

   hb_pwm_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_tb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .period_i (period_i),
      .duty_i   (duty_i),
      .dtime_i  (dtime_i),
      .pri_o    (pri),
      .dt_o     (dt_cur),
      .wrap_o   (wrap),
      .pm_o     (period_match_o),
      .ready_o  (ready_o)
   );

   hb_pwm_trip #(.N_CMP(N_CMP), .N_EXT(N_EXT), .EXT_RISE(EXT_RISE)) u_trip (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .restart_en_i (restart_en_i),
      .cmp_i        (cmp_trip_i),
      .ext_i        (ext_trip_i),
      .sw_wr_i      (sw_wr_i),
      .sw_wdata_i   (sw_wdata_i),
      .wrap_i       (wrap),
      .trip_o       (trip),
      .run_o        (run)
   );

   assign out_en = run & ~trip;

   hb_pwm_deadband #(.DT_W(DT_W)) u_db (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (out_en),
      .pri_i   (pri),
      .dt_i    (dt_cur),
      .pol_a_i (pol_a_i),
      .pol_b_i (pol_b_i),
      .a_act_o (a_act),
      .b_act_o (b_act),
      .drv_a_o (drv_a_o),
      .drv_b_o (drv_b_o)
   );

   assign trip_o = trip;

endmodule

// File: rtl/hb_pwm_chk.sv
module hb_pwm_chk #(
   parameter int N_CMP    = 2,
   parameter int N_EXT    = 1,
   parameter bit EXT_RISE = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             restart_en_i,
   input logic [N_CMP-1:0] cmp_i,
   input logic [N_EXT-1:0] ext_i,
   input logic             sw_wr_i,
   input logic             trip_i,
   input logic             run_i,
   input logic             wrap_i,
   input logic             a_act_i,
   input logic             b_act_i,
   input logic             ready_i
);

   logic ext_any;
   assign ext_any = EXT_RISE ? (|ext_i) : (|(~ext_i));

   // R3
   no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(a_act_i && b_act_i));

   // R12
   safe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip_i |=> (!a_act_i && !b_act_i));

   // R9
   cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|cmp_i) |=> trip_i);

   // R8
   resume_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_i) |-> $past(wrap_i));

   // R7
   latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!restart_en_i && trip_i && !sw_wr_i) |=> trip_i);

   // R6
   auto_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (restart_en_i && trip_i && !(|cmp_i) && !ext_any && !sw_wr_i) |=> !trip_i);

   // R13
   ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_i |=> ready_i);

endmodule

bind hb_pwm_top hb_pwm_chk #(.N_CMP(N_CMP), .N_EXT(N_EXT), .EXT_RISE(EXT_RISE)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .restart_en_i (restart_en_i),
   .cmp_i        (cmp_trip_i),
   .ext_i        (ext_trip_i),
   .sw_wr_i      (sw_wr_i),
   .trip_i       (trip),
   .run_i        (run),
   .wrap_i       (wrap),
   .a_act_i      (a_act),
   .b_act_i      (b_act),
   .ready_i      (ready_o)
);

// File: tb/hb_pwm_top_tb_top.sv
module hb_pwm_top_tb_top;

   localparam int CNT_W = 8;
   localparam int DT_W  = 4;
   localparam int N_CMP = 2;
   localparam int N_EXT = 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] period = 8'd9;
   logic [CNT_W-1:0] duty = 8'd4;
   logic [DT_W-1:0]  dtime = '0;
   logic             pol_a = 1'b0;
   logic             pol_b = 1'b0;
   logic             restart_en = 1'b1;
   logic [N_CMP-1:0] cmp = '0;
   logic [N_EXT-1:0] ext = '0;
   logic             sw_wr = 1'b0;
   logic             sw_wdata = 1'b0;
   logic             drv_a, drv_b, trip, pm, ready;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   hb_pwm_top #(.CNT_W(CNT_W), .DT_W(DT_W), .N_CMP(N_CMP), .N_EXT(N_EXT)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .period_i(period), .duty_i(duty), .dtime_i(dtime),
      .pol_a_i(pol_a), .pol_b_i(pol_b), .restart_en_i(restart_en),
      .cmp_trip_i(cmp), .ext_trip_i(ext), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
      .drv_a_o(drv_a), .drv_b_o(drv_b), .trip_o(trip),
      .period_match_o(pm), .ready_o(ready)
   );

   typedef struct {
      string req;
      int    due;
      int    len;
      int    on_a;
      int    on_b;
   } item_t;

   item_t sb_q[$];
   int    pm_idx = 0;
   int    w_len = 0, w_a = 0, w_b = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: counts one window per boundary and pops due items
   always @(negedge clk) begin
      if (rst_n) begin
         if (pm) begin
            pm_idx++;
            if (sb_q.size() > 0 && sb_q[0].due == pm_idx) begin
               chk({sb_q[0].req, " length"}, w_len, sb_q[0].len);
               chk({sb_q[0].req, " A on"},   w_a,   sb_q[0].on_a);
               chk({sb_q[0].req, " B on"},   w_b,   sb_q[0].on_b);
               void'(sb_q.pop_front());
            end
            w_len = 1;
            w_a   = int'(drv_a ^ pol_a);
            w_b   = int'(drv_b ^ pol_b);
         end else begin
            w_len++;
            w_a += int'(drv_a ^ pol_a);
            w_b += int'(drv_b ^ pol_b);
         end
      end
   end

   task automatic wait_pm();
      do @(negedge clk); while (!pm);
      #2;
   endtask

   task automatic expect_win(input string req, input int len, input int ea, input int eb);
      item_t it;
      it.req = req; it.due = pm_idx + 1; it.len = len; it.on_a = ea; it.on_b = eb;
      sb_q.push_back(it);
   endtask

   task automatic run_steady(input string req, input int p, input int d, input int g,
                             input int ea, input int eb);
      period = CNT_W'(p); duty = CNT_W'(d); dtime = DT_W'(g);
      wait_pm();
      wait_pm();
      expect_win(req, p + 1, ea, eb);
      wait_pm();
   endtask

   task automatic sw_write(input logic v);
      @(negedge clk); sw_wr = 1'b1; sw_wdata = v;
      @(negedge clk); sw_wr = 1'b0; sw_wdata = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all-reqs actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int bad;
      // reset state
      repeat (3) @(negedge clk);
      chk("R12 reset drv_a", int'(drv_a), 0);
      chk("R12 reset drv_b", int'(drv_b), 0);
      chk("R6 reset trip", int'(trip), 0);
      chk("R1 reset pm", int'(pm), 0);
      chk("R13 reset ready", int'(ready), 0);
      rst_n = 1'b1;

      // R13: not ready at first boundary, ready after the second
      wait_pm();
      chk("R13 ready at first pm", int'(ready), 0);
      wait_pm();
      @(negedge clk);
      chk("R13 ready after second pm", int'(ready), 1);

      // R1 R2 basic duty
      run_steady("R1 R2 p9 d4", 9, 4, 0, 4, 6);
      // R3 guard interval
      run_steady("R3 p15 d10 g3", 15, 10, 3, 7, 3);
      // R2 duty 0
      run_steady("R2 duty zero", 7, 0, 2, 0, 8);
      // R2 duty above period
      run_steady("R2 duty over period", 7, 20, 2, 8, 0);

      // R5: mid-period change takes effect only at next boundary
      run_steady("R5 base", 9, 4, 0, 4, 6);
      duty = 8'd7;
      expect_win("R5 old duty kept", 10, 4, 6);
      wait_pm();
      wait_pm();
      expect_win("R5 new duty", 10, 7, 3);
      wait_pm();

      // R9 R12 comparator trip, R6 auto restart, R8 resume at boundary
      restart_en = 1'b1;
      @(negedge clk); cmp = 2'b10;
      @(negedge clk);
      chk("R9 trip set by comparator", int'(trip), 1);
      @(negedge clk);
      chk("R12 drv_a off", int'(drv_a), 0);
      chk("R12 drv_b off", int'(drv_b), 0);
      sw_write(1'b0);
      chk("R9 clear write ignored", int'(trip), 1);
      cmp = '0;
      @(negedge clk);
      chk("R6 auto clear", int'(trip), 0);
      bad = 0;
      while (!pm) begin
         bad += int'(drv_a | drv_b);
         @(negedge clk);
      end
      #2;
      chk("R8 off until boundary", bad, 0);
      wait_pm();
      expect_win("R8 resumed window", 10, 7, 3);
      wait_pm();

      // R11 R7 latched external trip
      restart_en = 1'b0;
      @(negedge clk); ext = 1'b1;
      @(negedge clk);
      chk("R11 ext edge sets trip", int'(trip), 1);
      ext = 1'b0;
      repeat (12) @(negedge clk);
      chk("R7 latched after fault gone", int'(trip), 1);
      chk("R12 latched drv_a off", int'(drv_a), 0);
      sw_write(1'b0);
      chk("R7 software clear", int'(trip), 0);

      // R10 force, R4 polarity off levels
      pol_a = 1'b1; pol_b = 1'b1;
      sw_write(1'b1);
      chk("R10 forced trip", int'(trip), 1);
      @(negedge clk);
      chk("R4 drv_a off level active-low", int'(drv_a), 1);
      chk("R4 drv_b off level active-low", int'(drv_b), 1);
      sw_write(1'b0);
      chk("R10 forced trip cleared", int'(trip), 0);
      restart_en = 1'b1;
      wait_pm();
      run_steady("R4 active-low duty", 9, 5, 1, 4, 4);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule